// File: doc/BRIEF.md
# Adjustable-Strength Majority-Logic Word Corrector

This block repairs a 64-bit word read back from storage. The word must be a member of a sparse parity code whose checks are the lines of a plane over GF(8). The checker is a stack of identical check groups. Each group reorders the incoming bits with its own fixed wiring and then feeds them to the same eight-row XOR block. A run-time strength input enables the first `gamma` groups. Groups above that are forced to zero and take no part in any decision.

For each bit, one check from every enabled group covers it, and no two of these checks share any other bit. A bit is flipped when strictly more than half of its enabled checks are unsatisfied. This repairs any pattern of up to floor(gamma/2) bit errors. Raising the strength buys more correction, and lowering it lets the unused groups idle.

A word is presented with `in_valid`. The repaired word appears one clock later, together with a flag that reports whether any enabled check failed. The strength must not change while a word is in flight.

Top module: `ecc_maj_decoder`

## Requirements
- R1: Bit index 8x+y is the plane point (x,y). Group 1 checks the columns (bits 8x..8x+7). Group 2 checks the rows (bits y, y+8, ..., y+56). Group k≥3 checks the lines y = (k-2)·x + b, computed in GF(8) with the polynomial x^3+x+1.
- R2: Any XOR of two parallel columns or two parallel rows is a codeword. At every strength such a word leaves the block unchanged, with the error flag low.
- R3: For every strength 2..8, a codeword with up to floor(strength/2) flipped bits is restored exactly.
- R4: The error flag is high exactly when at least one check of an enabled group is odd.
- R5: Disabled groups are excluded from detection and from the vote. Flipping bits 0, 1, 8 and 9 of a codeword satisfies groups 1..3. At strength 2 or 3 this gives a low flag and the word passes through unmodified. At strength 4 the flag goes high.
- R6: A strength below 2 acts as 2, and a strength above 8 acts as 8.
- R7: `out_valid` is `in_valid` delayed by exactly one clock. The word and flag belong to the input of that earlier cycle.
- R8: While `in_valid` is low, `out_word` and `out_err_seen` hold their last values.
- R9: After a synchronous reset, `out_valid`, `out_word` and `out_err_seen` are all zero.
- R10: When the flag is low, the output word equals the input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 64 | Received word |
| strength | input | 4 | Number of enabled check groups (clamped to 2..8) |
| out_valid | output | 1 | Output word is valid |
| out_word | output | 64 | Corrected word |
| out_err_seen | output | 1 | Some enabled check was odd |

## Verification
The threshold boundary is exercised at every strength with exactly floor(strength/2) random errors. A vote that used "at least half" would flip good bits that share a line with an error, and one that required more votes would leave errors in place. The four-bit square pattern passes the first three groups but fails the rest. A design that counted disabled groups as failing, or left them connected, would raise the flag at strength 2 or 3. Strengths 0, 1, 9 and 15 check the clamp: an unclamped zero would repair nothing, and an unclamped large value would select no real configuration.

// File: rtl/ecc_maj_pkg.sv
package ecc_maj_pkg;

  // Multiply two elements of GF(2^m) given the reduction polynomial (bit m set).
  function automatic int gf_mul(input int m, input int poly, input int a, input int b);
    int acc;
    int sh;
    acc = 0;
    sh  = a;
    for (int i = 0; i < m; i++) begin
      if (((b >> i) & 1) == 1) acc = acc ^ sh;
      sh = sh << 1;
      if (((sh >> m) & 1) == 1) sh = sh ^ poly;
    end
    return acc;
  endfunction

  // Line (check row) of group u that passes through bit p = x*q + y.
  // Group 0: vertical lines x = c. Group u>0: y = (u-1)*x + b, line index b.
  function automatic int line_of(input int m, input int poly, input int u, input int p);
    int q;
    int x;
    int y;
    q = 1 << m;
    x = p / q;
    y = p % q;
    if (u == 0) return x;
    return y ^ gf_mul(m, poly, u - 1, x);
  endfunction

  // Source bit for permuted position pos = line*q + k of group u.
  function automatic int src_of(input int m, input int poly, input int u, input int pos);
    int q;
    int b;
    int x;
    q = 1 << m;
    if (u == 0) return pos;
    b = pos / q;
    x = pos % q;
    return x * q + (gf_mul(m, poly, u - 1, x) ^ b);
  endfunction

endpackage

// File: rtl/ecc_xor_block.sv
module ecc_xor_block #(
  parameter int ROWS = 8,
  parameter int RHO  = 8
) (
  input  logic [ROWS*RHO-1:0] bits_i,
  output logic [ROWS-1:0]     par_o
);
  // Base check block: each row covers RHO contiguous bits, one 1 per column.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign par_o[r] = ^bits_i[r*RHO +: RHO];
  end
endmodule

// File: rtl/ecc_check_unit.sv
module ecc_check_unit
  import ecc_maj_pkg::*;
#(
  parameter int GF_M    = 3,
  parameter int GF_POLY = 11,
  parameter int UNIT    = 0,
  localparam int Q      = 1 << GF_M,
  localparam int N      = Q * Q
) (
  input  logic [N-1:0] word_i,
  input  logic         en_i,
  output logic [Q-1:0] chk_o
);
  logic [N-1:0] perm;
  logic [Q-1:0] raw;

  // Group-specific wiring that turns this bundle of lines into contiguous rows.
  for (genvar pos = 0; pos < N; pos++) begin : g_perm
    localparam int SRC = src_of(GF_M, GF_POLY, UNIT, pos);
    assign perm[pos] = word_i[SRC];
  end

  ecc_xor_block #(.ROWS(Q), .RHO(Q)) u_xor (
    .bits_i (perm),
    .par_o  (raw)
  );

  // A disabled group reports no failing check.
  assign chk_o = en_i ? raw : '0;
endmodule

// File: rtl/ecc_bit_vote.sv
module ecc_bit_vote #(
  parameter int UNITS = 8,
  localparam int CW   = $clog2(UNITS + 1)
) (
  input  logic [UNITS-1:0] votes_i,
  input  logic [CW-1:0]    thresh_i,
  output logic             flip_o
);
  logic [CW-1:0] cnt;

  always_comb begin
    cnt = '0;
    for (int u = 0; u < UNITS; u++) begin
      cnt = cnt + CW'(votes_i[u]);
    end
  end

  assign flip_o = (cnt > thresh_i);
endmodule

// File: rtl/ecc_maj_decoder.sv
module ecc_maj_decoder
  import ecc_maj_pkg::*;
#(
  parameter int GF_M      = 3,
  parameter int GF_POLY   = 11,
  parameter int GAMMA_MIN = 2,
  parameter int GAMMA_MAX = 8,
  localparam int Q        = 1 << GF_M,
  localparam int WORD_W   = Q * Q,
  localparam int UNITS    = GAMMA_MAX,
  localparam int SW       = $clog2(GAMMA_MAX + 1),
  localparam int CW       = $clog2(UNITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [SW-1:0]     strength,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_err_seen
);
  logic [SW-1:0]     g_eff;
  logic [SW-1:0]     g_half;
  logic [CW-1:0]     thresh;
  logic [UNITS-1:0]  unit_en;
  logic [Q-1:0]      chk   [UNITS];
  logic [UNITS-1:0]  votes [WORD_W];
  logic [UNITS-1:0]  unit_any;
  logic [WORD_W-1:0] est;
  logic [WORD_W-1:0] fixed;
  logic              any_fail;

  // Clamp the requested strength into the legal range.
  always_comb begin
    if (strength < SW'(GAMMA_MIN))      g_eff = SW'(GAMMA_MIN);
    else if (strength > SW'(GAMMA_MAX)) g_eff = SW'(GAMMA_MAX);
    else                                g_eff = strength;
  end

  assign g_half = g_eff >> 1;
  assign thresh = CW'(g_half);

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    assign unit_en[u] = (g_eff > SW'(u));

    ecc_check_unit #(
      .GF_M    (GF_M),
      .GF_POLY (GF_POLY),
      .UNIT    (u)
    ) u_chk (
      .word_i (in_word),
      .en_i   (unit_en[u]),
      .chk_o  (chk[u])
    );

    assign unit_any[u] = |chk[u];
  end

  // Route each bit's orthogonal checks to its vote.
  for (genvar p = 0; p < WORD_W; p++) begin : g_bit
    for (genvar u = 0; u < UNITS; u++) begin : g_src
      localparam int LN = line_of(GF_M, GF_POLY, u, p);
      assign votes[p][u] = chk[u][LN];
    end

    ecc_bit_vote #(.UNITS(UNITS)) u_vote (
      .votes_i  (votes[p]),
      .thresh_i (thresh),
      .flip_o   (est[p])
    );
  end

  assign fixed    = in_word ^ est;
  assign any_fail = |unit_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_word     <= '0;
      out_err_seen <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word     <= fixed;
        out_err_seen <= any_fail;
      end
    end
  end
endmodule

// File: rtl/ecc_maj_decoder_chk.sv
module ecc_maj_decoder_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_word,
  input logic         out_valid,
  input logic [W-1:0] out_word,
  input logic         out_err_seen
);
  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_word) && $stable(out_err_seen)));

  assert_zero_word_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word == '0) |=> (out_word == '0 && !out_err_seen));

  assert_no_flag_no_flip_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_err_seen || out_word == $past(in_word)));
endmodule

bind ecc_maj_decoder ecc_maj_decoder_chk #(.W(WORD_W)) u_chk_bind (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_word      (in_word),
  .out_valid    (out_valid),
  .out_word     (out_word),
  .out_err_seen (out_err_seen)
);

// File: tb/ecc_maj_decoder_bench.sv
`timescale 1ns/1ps
module ecc_maj_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic [3:0]  strength = 4'd2;
  logic        out_valid;
  logic [63:0] out_word;
  logic        out_err_seen;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  ecc_maj_decoder u_ecc_maj_decoder (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_word      (in_word),
    .strength     (strength),
    .out_valid    (out_valid),
    .out_word     (out_word),
    .out_err_seen (out_err_seen)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R1 layout: column x = bits 8x..8x+7, row y = bits y, y+8, ...
  function automatic logic [63:0] col_mask(input int c);
    return 64'hFF << (8 * c);
  endfunction

  function automatic logic [63:0] row_mask(input int r);
    return 64'h0101010101010101 << r;
  endfunction

  function automatic logic [63:0] rand_cw();
    logic [63:0] cw = '0;
    repeat (3) begin
      int a = $urandom % 8;
      int b = (a + 1 + ($urandom % 7)) % 8;
      cw = cw ^ col_mask(a) ^ col_mask(b);
      a = $urandom % 8;
      b = (a + 1 + ($urandom % 7)) % 8;
      cw = cw ^ row_mask(a) ^ row_mask(b);
    end
    return cw;
  endfunction

  function automatic logic [63:0] rand_err(input int t);
    logic [63:0] e = '0;
    while ($countones(e) < t) e[$urandom % 64] = 1'b1;
    return e;
  endfunction

  task automatic xfer(input logic [63:0] w, input logic [3:0] g,
                      output logic [63:0] ow, output logic oe, output logic ov);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    strength = g;
    @(negedge clk);
    in_valid = 1'b0;
    ow = out_word;
    oe = out_err_seen;
    ov = out_valid;
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R9 valid", {63'd0, out_valid}, 64'd0);
    check(out_word == 64'd0, "R9 word", out_word, 64'd0);
    check(out_err_seen == 1'b0, "R9 flag", {63'd0, out_err_seen}, 64'd0);
  endtask

  task automatic t_clean();
    logic [63:0] ow;
    logic oe, ov;
    for (int g = 2; g <= 8; g++) begin
      for (int k = 0; k < 4; k++) begin
        logic [63:0] cw = (k == 0) ? 64'hFFFF_FFFF_FFFF_FFFF : rand_cw();
        xfer(cw, 4'(g), ow, oe, ov);
        check(ow == cw, "R2 R1 codeword unchanged", ow, cw);
        check(!oe, "R2 flag low", {63'd0, oe}, 64'd0);
      end
    end
  endtask

  task automatic t_correct();
    logic [63:0] ow;
    logic oe, ov;
    for (int g = 2; g <= 8; g++) begin
      for (int k = 0; k < 20; k++) begin
        int t = (k < 14) ? g / 2 : 1 + ($urandom % (g / 2));
        logic [63:0] cw = rand_cw();
        logic [63:0] e  = rand_err(t);
        xfer(cw ^ e, 4'(g), ow, oe, ov);
        check(ow == cw, "R3 restored", ow, cw);
        check(oe, "R4 flag high on error", {63'd0, oe}, 64'd1);
      end
    end
  endtask

  task automatic t_disabled();
    logic [63:0] ow;
    logic oe, ov;
    logic [63:0] cw = rand_cw();
    logic [63:0] sq = 64'h0303;
    for (int g = 2; g <= 3; g++) begin
      xfer(cw ^ sq, 4'(g), ow, oe, ov);
      check(!oe, "R5 disabled groups excluded from flag", {63'd0, oe}, 64'd0);
      check(ow == (cw ^ sq), "R5 word untouched", ow, cw ^ sq);
    end
    xfer(cw ^ sq, 4'd4, ow, oe, ov);
    check(oe, "R5 R4 group 4 detects square", {63'd0, oe}, 64'd1);
  endtask

  task automatic t_clamp();
    logic [63:0] ow;
    logic oe, ov;
    logic [63:0] cw;
    cw = rand_cw();
    xfer(cw ^ rand_err(1), 4'd0, ow, oe, ov);
    check(ow == cw, "R6 strength 0 acts as 2", ow, cw);
    cw = rand_cw();
    xfer(cw ^ rand_err(1), 4'd1, ow, oe, ov);
    check(ow == cw, "R6 strength 1 acts as 2", ow, cw);
    for (int k = 0; k < 4; k++) begin
      cw = rand_cw();
      xfer(cw ^ rand_err(4), (k < 2) ? 4'd9 : 4'd15, ow, oe, ov);
      check(ow == cw, "R6 large strength acts as 8", ow, cw);
    end
  endtask

  task automatic t_latency();
    logic [63:0] ow;
    logic oe, ov;
    xfer(64'd0, 4'd8, ow, oe, ov);
    check(ov, "R7 valid one cycle later", {63'd0, ov}, 64'd1);
    @(negedge clk);
    check(!out_valid, "R7 valid drops", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_hold();
    logic [63:0] ow;
    logic oe, ov;
    logic [63:0] cw = rand_cw();
    logic [63:0] e  = rand_err(2);
    xfer(cw ^ e, 4'd5, ow, oe, ov);
    in_word = ~cw;
    repeat (3) @(negedge clk);
    check(out_word == ow, "R8 word held", out_word, ow);
    check(out_err_seen == oe, "R8 flag held", {63'd0, out_err_seen}, {63'd0, oe});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_clean();
    t_correct();
    t_disabled();
    t_clamp();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_fail);
    $finish;
  end
endmodule